// File: doc/BRIEF.md
# Biased Exponent Adder with Hardwired Bias Removal

This block forms the intermediate exponent of a floating-point product. It takes two biased exponent fields, adds them in a ripple carry chain, and keeps the chain's final carry as an extra sum bit. It then removes one copy of the bias, 2^(EXP_W-1)-1 (127 for 8-bit exponents), so that the bias is counted only once. The bias is removed by a ripple borrow chain. Each cell in that chain is built for a fixed subtrahend bit: cells for a 1 bit handle the low EXP_W-1 positions, and cells for a 0 bit handle the two top positions. No general subtractor is used.

The result comes out as a signed value two bits wider than an exponent field. Two range flags come with it: one for a negative result and one for a result at or above the all-ones exponent code. A normalizer or exception stage downstream uses these flags. All outputs are registered and appear one clock after the inputs are sampled. Normalization and the significand path belong to other blocks.

Top module: `exp_bias_adder`

## Requirements
- R1: One cycle after inputs A and B are sampled, `res_exp` read as two's complement equals A + B - 127 (for EXP_W = 8). This holds over the whole 1..254 input range, so results run from -125 to 381.
- R2: Outputs are registered. Changing the inputs leaves every output unchanged until the next rising clock edge.
- R3: `neg_flag` is 1 exactly when the R1 result is below zero.
- R4: `borrow_out`, the final borrow of the bias chain, is 1 exactly when the R1 result is below zero.
- R5: `big_flag` is 1 exactly when the R1 result is 255 or more.
- R6: `neg_flag` and `big_flag` are never 1 together.
- R7: While `rst` (synchronous, active high) is sampled high, all outputs are 0 after that edge, whatever the inputs are.
- R8: When A + B carries out of the 8-bit adder, that carry counts as weight 256. For example, 254 + 254 gives 381 and 200 + 200 gives 273.
- R9: Edge results: A + B = 127 gives 0 with no flag raised; A + B = 126 gives -1 with `neg_flag` set; a result of 254 raises no flag; a result of 255 sets `big_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exp_a | input | EXP_W | First biased exponent |
| exp_b | input | EXP_W | Second biased exponent |
| res_exp | output | EXP_W+2 | Signed intermediate exponent, two's complement |
| borrow_out | output | 1 | Final borrow of the bias chain |
| neg_flag | output | 1 | Result below zero |
| big_flag | output | 1 | Result at or above the all-ones exponent code |

## Verification
Every pair of legal exponents, 1..254 on each side, is applied on consecutive cycles, and each result is compared with an integer reference. This catches a broken carry or borrow link at any bit position, because each link is exercised both with and without a carry or borrow arriving. Pairs with and without an adder carry out separate a lost ninth sum bit from a wrong bias. The sums 126, 127, 381 and 382 land right where each flag changes state, so an off-by-one compare in either flag shows up. Applying reset with large inputs present, and checking outputs just after new inputs arrive, exposes any combinational leak past the output registers.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

  typedef struct packed {
    logic neg;
    logic big;
  } ebs_range_t;

  function automatic int unsigned ebs_bias(input int unsigned exp_w);
    return (32'd1 << (exp_w - 1)) - 32'd1;
  endfunction

endpackage

// File: rtl/ebs_cells.sv
// Adder cells
module ebs_half_add (
  input  logic a,
  input  logic b,
  output logic s,
  output logic co
);
  assign s  = a ^ b;
  assign co = a & b;
endmodule

module ebs_full_add (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = a ^ b ^ ci;
  assign co = (a & b) | (ci & (a ^ b));
endmodule

// Subtractor cell for a subtrahend bit fixed at 1
module ebs_sub_one (
  input  logic s,
  input  logic bi,
  output logic d,
  output logic bo
);
  assign d  = ~(s ^ bi);
  assign bo = ~s | bi;
endmodule

// Subtractor cell for a subtrahend bit fixed at 0
module ebs_sub_zero (
  input  logic s,
  input  logic bi,
  output logic d,
  output logic bo
);
  assign d  = s ^ bi;
  assign bo = ~s & bi;
endmodule

// File: rtl/ebs_ripple_add.sv
module ebs_ripple_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W:0]   sum
);
  logic [W-1:0] carry;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_half
      ebs_half_add u_cell (
        .a(a[i]), .b(b[i]), .s(sum[i]), .co(carry[i])
      );
    end else begin : g_full
      ebs_full_add u_cell (
        .a(a[i]), .b(b[i]), .ci(carry[i-1]), .s(sum[i]), .co(carry[i])
      );
    end
  end

  assign sum[W] = carry[W-1];
endmodule

// File: rtl/ebs_bias_sub.sv
module ebs_bias_sub #(
  parameter int          W = 9,
  parameter int unsigned K = 127
) (
  input  logic [W-1:0] minuend,
  output logic [W-1:0] diff,
  output logic         borrow
);
  logic [W:0] bchain;
  assign bchain[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_cell
    if (((K >> i) & 32'd1) != 32'd0) begin : g_one
      ebs_sub_one u_cell (
        .s(minuend[i]), .bi(bchain[i]), .d(diff[i]), .bo(bchain[i+1])
      );
    end else begin : g_zero
      ebs_sub_zero u_cell (
        .s(minuend[i]), .bi(bchain[i]), .d(diff[i]), .bo(bchain[i+1])
      );
    end
  end

  assign borrow = bchain[W];
endmodule

// File: rtl/exp_bias_adder.sv
module exp_bias_adder
  import ebs_pkg::*;
#(
  parameter int EXP_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [EXP_W-1:0]        exp_a,
  input  logic [EXP_W-1:0]        exp_b,
  output logic signed [EXP_W+1:0] res_exp,
  output logic                    borrow_out,
  output logic                    neg_flag,
  output logic                    big_flag
);
  localparam int          SUM_W   = EXP_W + 1;
  localparam int          RES_W   = EXP_W + 2;
  localparam int unsigned BIAS    = ebs_bias(EXP_W);
  localparam int unsigned TOP_EXP = (32'd1 << EXP_W) - 32'd1;

  logic [SUM_W-1:0] raw_sum;
  logic [SUM_W-1:0] unbiased;
  logic             chain_borrow;
  ebs_range_t       rng;
  logic [RES_W-1:0] res_d;

  ebs_ripple_add #(.W(EXP_W)) u_add (
    .a(exp_a), .b(exp_b), .sum(raw_sum)
  );

  ebs_bias_sub #(.W(SUM_W), .K(BIAS)) u_sub (
    .minuend(raw_sum), .diff(unbiased), .borrow(chain_borrow)
  );

  always_comb begin
    rng.neg = chain_borrow;
    rng.big = ~chain_borrow && (unbiased >= SUM_W'(TOP_EXP));
    res_d   = {chain_borrow, unbiased};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_exp    <= '0;
      borrow_out <= 1'b0;
      neg_flag   <= 1'b0;
      big_flag   <= 1'b0;
    end else begin
      res_exp    <= $signed(res_d);
      borrow_out <= chain_borrow;
      neg_flag   <= rng.neg;
      big_flag   <= rng.big;
    end
  end
endmodule

// File: rtl/exp_bias_adder_chk.sv
module exp_bias_adder_chk #(
  parameter int EXP_W = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic [EXP_W-1:0]        exp_a,
  input logic [EXP_W-1:0]        exp_b,
  input logic signed [EXP_W+1:0] res_exp,
  input logic                    borrow_out,
  input logic                    neg_flag,
  input logic                    big_flag
);
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int TOP_EXP = (1 << EXP_W) - 1;

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= !rst;

  AST_SUM_VALUE: assert property (@(posedge clk) disable iff (rst)
    armed |-> (int'(res_exp) == int'($past(exp_a)) + int'($past(exp_b)) - BIAS)); // R1
  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (rst)
    armed |-> (neg_flag == (int'($past(exp_a)) + int'($past(exp_b)) < BIAS))); // R3
  AST_BORROW: assert property (@(posedge clk) disable iff (rst)
    armed |-> (borrow_out == (int'($past(exp_a)) + int'($past(exp_b)) < BIAS))); // R4
  AST_BIG_FLAG: assert property (@(posedge clk) disable iff (rst)
    armed |-> (big_flag == (int'($past(exp_a)) + int'($past(exp_b)) - BIAS >= TOP_EXP))); // R5
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({neg_flag, big_flag})); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (res_exp == '0 && !borrow_out && !neg_flag && !big_flag)); // R7
endmodule

bind exp_bias_adder exp_bias_adder_chk #(.EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst(rst), .exp_a(exp_a), .exp_b(exp_b), .res_exp(res_exp),
  .borrow_out(borrow_out), .neg_flag(neg_flag), .big_flag(big_flag)
);

// File: tb/exp_bias_adder_test.sv
module exp_bias_adder_test;
  localparam int EXP_W = 8;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic [EXP_W-1:0]        exp_a = '0;
  logic [EXP_W-1:0]        exp_b = '0;
  logic signed [EXP_W+1:0] res_exp;
  logic                    borrow_out, neg_flag, big_flag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int    exp_q[$];
  string tag_q[$];

  exp_bias_adder #(.EXP_W(EXP_W)) uut (
    .clk(clk), .rst(rst), .exp_a(exp_a), .exp_b(exp_b), .res_exp(res_exp),
    .borrow_out(borrow_out), .neg_flag(neg_flag), .big_flag(big_flag)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic compare(input int e, input string tag);
    chk({tag, " R1 value"}, int'(res_exp), e);
    chk({tag, " R4 borrow"}, int'(borrow_out), int'(e < 0));
    chk({tag, " R3 neg"}, int'(neg_flag), int'(e < 0));
    chk({tag, " R5 big"}, int'(big_flag), int'(e >= 255));
    chk({tag, " R6 exclusive"}, int'(neg_flag & big_flag), 0);
  endtask

  // Drive one pair at a falling edge; compare the pair driven one cycle earlier.
  task automatic step(input int a, input int b, input string tag);
    int prev;
    string ptag;
    @(negedge clk);
    prev = 0;
    if (exp_q.size() > 0) begin
      prev = exp_q.pop_front();
      ptag = tag_q.pop_front();
      compare(prev, ptag);
    end
    exp_a = EXP_W'(a);
    exp_b = EXP_W'(b);
    exp_q.push_back(a + b - 127);
    tag_q.push_back(tag);
    #2;
    if (ptag.len() > 0) chk("R2 output held until edge", int'(res_exp), prev);
  endtask

  task automatic flush();
    @(negedge clk);
    while (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL R2 watchdog actual=%0d expected=<200000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R7: reset with large inputs present
    exp_a = 8'd254;
    exp_b = 8'd254;
    repeat (3) @(negedge clk);
    chk("R7 reset value", int'(res_exp), 0);
    chk("R7 reset borrow", int'(borrow_out), 0);
    chk("R7 reset neg", int'(neg_flag), 0);
    chk("R7 reset big", int'(big_flag), 0);
    rst = 1'b0;

    // R8 and R9 directed corners
    step(254, 254, "R8 max carry");
    step(200, 200, "R8 carry");
    step(100, 27,  "R9 zero");
    step(100, 26,  "R9 minus one");
    step(191, 190, "R9 top normal");
    step(191, 191, "R9 first big");
    step(1, 1,     "R9 min");

    // Exhaustive sweep
    for (int a = 1; a <= 254; a++)
      for (int b = 1; b <= 254; b++)
        step(a, b, "sweep");
    flush();

    // R7: reset mid-stream
    @(negedge clk);
    exp_a = 8'd250;
    exp_b = 8'd250;
    rst = 1'b1;
    @(negedge clk);
    chk("R7 mid reset value", int'(res_exp), 0);
    chk("R7 mid reset big", int'(big_flag), 0);
    rst = 1'b0;
    @(negedge clk);
    compare(373, "R7 after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule